// File: doc/BRIEF.md
# Byte-serial instruction decoder

This block accepts machine-code bytes one per clock on a valid/ready input and recognises a small set of 32-bit-mode encodings. The encodings are: the move-immediate-to-register family, the software-interrupt opcode, and an optional operand-size prefix that may stand in front of either. When the final byte of an instruction is taken, the block emits a single-cycle result. The result carries the instruction kind, the destination register code, an operand-size flag, the immediate reassembled into one word, and the instruction length in bytes.

A byte that is neither a prefix nor a supported opcode where an opcode is expected produces a single-cycle error pulse. The decoder then starts over with the next byte. Typical use is a front-end sniffer or a test harness. It sits on a byte stream from an instruction fetch buffer and turns the supported encodings into decoded records.

Top module: `insn_stream_decoder`

## Requirements
- R1: While `rst_i` is high, and on the first cycle after it falls, `done_o` and `err_o` are 0. Reset discards any partial instruction and any stored prefix, so the next byte is decoded as a fresh prefix or opcode.
- R2: Any opcode byte whose bits [7:3] equal 5'b10111 (0xB8 to 0xBF) is a move. The result reports `kind_o` = 2'd1 and `reg_o` = opcode bits [2:0]. For example, 0xB8 gives 0 and 0xBB gives 3.
- R3: A move with no prefix takes four immediate bytes, least significant first. The result reports `size16_o` = 0 and `len_o` = 5. For example, B8 AA BB CC DD gives immediate 0xDDCCBBAA.
- R4: A move preceded by 0x66 takes two immediate bytes, least significant first. The result reports `imm_o` zero-extended, `size16_o` = 1 and `len_o` = 4.
- R5: Opcode 0xCD is a software interrupt followed by one vector byte. The result reports `kind_o` = 2'd2, `reg_o` = 0, `imm_o` = the vector zero-extended, `size16_o` = 0 and `len_o` = 2.
- R6: A 0x66 prefix before 0xCD is accepted without error. The vector stays one byte, and the result reports `size16_o` = 1 and `len_o` = 3.
- R7: An unsupported byte in opcode position gives `err_o` = 1 for one cycle, with no `done_o`. The stored prefix is dropped, and the next byte starts a new instruction.
- R8: A second 0x66 directly after a first one is treated as unsupported. It raises `err_o` and clears the prefix.
- R9: `done_o` is high for exactly the one cycle after the last byte of an instruction is accepted. `done_o` and `err_o` are never high together. Cycles with `in_valid_i` low inside an instruction change neither the timing nor the content of the result.
- R10: `in_ready_o` is 0 while `rst_i` is high and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| in_valid_i | input | 1 | Input byte is valid |
| in_byte_i | input | 8 | Instruction byte |
| in_ready_o | output | 1 | Decoder can take a byte |
| done_o | output | 1 | One-cycle pulse: result fields valid |
| err_o | output | 1 | One-cycle pulse: unsupported opcode |
| kind_o | output | 2 | 1 = move immediate, 2 = software interrupt |
| reg_o | output | 3 | Destination register code |
| size16_o | output | 1 | Operand-size prefix was present |
| imm_o | output | 32 | Assembled immediate, zero-extended |
| len_o | output | 4 | Instruction length in bytes |

## Verification
Every result and error flag is registered once. Both are therefore due in the cycle right after the clock edge that accepts the last byte of an instruction, or the offending byte. The bench drives each byte half a period before an edge. It reads the result at the following falling edge, exactly one register stage later. It also confirms that the pulses are absent at every falling edge between bytes and stall cycles, and at the falling edge after the result.

// File: rtl/insn_dec_pkg.sv
package insn_dec_pkg;

    typedef enum logic [1:0] {
        KIND_NONE = 2'd0,
        KIND_MOVE = 2'd1,
        KIND_TRAP = 2'd2
    } kind_e;

    typedef enum logic {
        PH_HEAD = 1'b0,
        PH_IMM  = 1'b1
    } phase_e;

    localparam logic [7:0] SIZE_PREFIX = 8'h66;
    localparam logic [7:0] TRAP_OPCODE = 8'hCD;
    localparam logic [4:0] MOVE_TOP    = 5'b10111;

endpackage

// File: rtl/insn_opclass.sv
module insn_opclass
    import insn_dec_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int REG_W  = 3
) (
    input  logic [BYTE_W-1:0] byte_i,
    output logic              is_prefix_o,
    output logic              is_move_o,
    output logic              is_trap_o,
    output logic [REG_W-1:0]  reg_o
);

    always_comb begin
        is_prefix_o = (byte_i == SIZE_PREFIX);
        is_trap_o   = (byte_i == TRAP_OPCODE);
        is_move_o   = (byte_i[BYTE_W-1:REG_W] == MOVE_TOP);
        reg_o       = byte_i[REG_W-1:0];
    end

endmodule

// File: rtl/insn_imm_merge.sv
module insn_imm_merge #(
    parameter int BYTE_W = 8,
    parameter int IMM_W  = 32,
    parameter int IDX_W  = 2
) (
    input  logic [IMM_W-1:0]  acc_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [IMM_W-1:0]  acc_o
);

    localparam int LANES = IMM_W / BYTE_W;

    for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
        assign acc_o[lane*BYTE_W +: BYTE_W] =
            (idx_i == IDX_W'(lane)) ? byte_i : acc_i[lane*BYTE_W +: BYTE_W];
    end

endmodule

// File: rtl/insn_stream_decoder.sv
module insn_stream_decoder
    import insn_dec_pkg::*;
#(
    parameter int IMM_W = 32,
    parameter int LEN_W = 4,
    parameter int REG_W = 3
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             in_valid_i,
    input  logic [7:0]       in_byte_i,
    output logic             in_ready_o,
    output logic             done_o,
    output logic             err_o,
    output logic [1:0]       kind_o,
    output logic [REG_W-1:0] reg_o,
    output logic             size16_o,
    output logic [IMM_W-1:0] imm_o,
    output logic [LEN_W-1:0] len_o
);

    localparam int BYTE_W     = 8;
    localparam int LANES      = IMM_W / BYTE_W;
    localparam int HALF_LANES = LANES / 2;
    localparam int IDX_W      = (LANES > 1) ? $clog2(LANES) : 1;

    typedef struct packed {
        phase_e             phase;
        logic               prefix;
        kind_e              kind;
        logic [REG_W-1:0]   regn;
        logic [IDX_W-1:0]   idx;
        logic [IDX_W-1:0]   last_idx;
        logic [IMM_W-1:0]   acc;
        logic               done;
        logic               err;
        kind_e              out_kind;
        logic [REG_W-1:0]   out_reg;
        logic               out_size;
        logic [IMM_W-1:0]   out_imm;
        logic [LEN_W-1:0]   out_len;
    } state_t;

    localparam state_t STATE_RESET = '0;

    state_t st_d, st_q;

    logic             accept;
    logic             cls_prefix;
    logic             cls_move;
    logic             cls_trap;
    logic [REG_W-1:0] cls_reg;
    logic [IMM_W-1:0] merged;

    insn_opclass #(
        .BYTE_W (BYTE_W),
        .REG_W  (REG_W)
    ) u_opclass (
        .byte_i      (in_byte_i),
        .is_prefix_o (cls_prefix),
        .is_move_o   (cls_move),
        .is_trap_o   (cls_trap),
        .reg_o       (cls_reg)
    );

    insn_imm_merge #(
        .BYTE_W (BYTE_W),
        .IMM_W  (IMM_W),
        .IDX_W  (IDX_W)
    ) u_imm_merge (
        .acc_i  (st_q.acc),
        .byte_i (in_byte_i),
        .idx_i  (st_q.idx),
        .acc_o  (merged)
    );

    assign in_ready_o = !rst_i;
    assign accept     = in_valid_i && in_ready_o;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.err  = 1'b0;

        if (accept) begin
            unique case (st_q.phase)
                PH_HEAD: begin
                    if (cls_prefix) begin
                        if (st_q.prefix) begin
                            st_d.err    = 1'b1;
                            st_d.prefix = 1'b0;
                        end else begin
                            st_d.prefix = 1'b1;
                        end
                    end else if (cls_move) begin
                        st_d.kind     = KIND_MOVE;
                        st_d.regn     = cls_reg;
                        st_d.idx      = '0;
                        st_d.last_idx = st_q.prefix ? IDX_W'(HALF_LANES - 1)
                                                    : IDX_W'(LANES - 1);
                        st_d.acc      = '0;
                        st_d.phase    = PH_IMM;
                    end else if (cls_trap) begin
                        st_d.kind     = KIND_TRAP;
                        st_d.regn     = '0;
                        st_d.idx      = '0;
                        st_d.last_idx = '0;
                        st_d.acc      = '0;
                        st_d.phase    = PH_IMM;
                    end else begin
                        st_d.err    = 1'b1;
                        st_d.prefix = 1'b0;
                    end
                end
                PH_IMM: begin
                    st_d.acc = merged;
                    if (st_q.idx == st_q.last_idx) begin
                        st_d.done     = 1'b1;
                        st_d.out_kind = st_q.kind;
                        st_d.out_reg  = st_q.regn;
                        st_d.out_size = st_q.prefix;
                        st_d.out_imm  = merged;
                        st_d.out_len  = LEN_W'(2) + LEN_W'(st_q.prefix)
                                      + LEN_W'(st_q.idx);
                        st_d.phase    = PH_HEAD;
                        st_d.prefix   = 1'b0;
                    end else begin
                        st_d.idx = st_q.idx + IDX_W'(1);
                    end
                end
                default: st_d = STATE_RESET;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= STATE_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign done_o   = st_q.done;
    assign err_o    = st_q.err;
    assign kind_o   = st_q.out_kind;
    assign reg_o    = st_q.out_reg;
    assign size16_o = st_q.out_size;
    assign imm_o    = st_q.out_imm;
    assign len_o    = st_q.out_len;

endmodule

// File: rtl/insn_dec_checker.sv
module insn_dec_checker #(
    parameter int IMM_W = 32,
    parameter int LEN_W = 4,
    parameter int REG_W = 3
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             in_valid_i,
    input logic             in_ready_o,
    input logic             done_o,
    input logic             err_o,
    input logic [1:0]       kind_o,
    input logic [REG_W-1:0] reg_o,
    input logic             size16_o,
    input logic [IMM_W-1:0] imm_o,
    input logic [LEN_W-1:0] len_o
);

    assert_pulse_excl_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        !(done_o && err_o));

    assert_done_single_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |=> !done_o);

    assert_done_follows_byte_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |-> $past(in_valid_i && in_ready_o));

    assert_err_follows_byte_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        err_o |-> $past(in_valid_i && in_ready_o));

    assert_kind_known_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |-> (kind_o == 2'd1 || kind_o == 2'd2));

    assert_move_wide_len_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (done_o && kind_o == 2'd1 && !size16_o) |-> (len_o == LEN_W'(5)));

    assert_move_narrow_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (done_o && kind_o == 2'd1 && size16_o) |->
            (len_o == LEN_W'(4) && (imm_o >> (IMM_W / 2)) == '0));

    assert_trap_shape_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (done_o && kind_o == 2'd2) |->
            ((imm_o >> 8) == '0 && reg_o == '0));

    assert_trap_len_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (done_o && kind_o == 2'd2) |->
            (len_o == (size16_o ? LEN_W'(3) : LEN_W'(2))));

endmodule

bind insn_stream_decoder insn_dec_checker #(
    .IMM_W (IMM_W),
    .LEN_W (LEN_W),
    .REG_W (REG_W)
) u_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .in_valid_i (in_valid_i),
    .in_ready_o (in_ready_o),
    .done_o     (done_o),
    .err_o      (err_o),
    .kind_o     (kind_o),
    .reg_o      (reg_o),
    .size16_o   (size16_o),
    .imm_o      (imm_o),
    .len_o      (len_o)
);

// File: tb/insn_stream_decoder_tb.sv
`timescale 1ns/1ps
module insn_stream_decoder_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        in_ready;
    logic        done;
    logic        err;
    logic [1:0]  kind;
    logic [2:0]  regc;
    logic        size16;
    logic [31:0] imm;
    logic [3:0]  len;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;
    logic [7:0] seq [6];

    always #4 clk = ~clk;

    insn_stream_decoder u_dut (
        .clk_i      (clk),
        .rst_i      (rst),
        .in_valid_i (in_valid),
        .in_byte_i  (in_byte),
        .in_ready_o (in_ready),
        .done_o     (done),
        .err_o      (err),
        .kind_o     (kind),
        .reg_o      (regc),
        .size16_o   (size16),
        .imm_o      (imm),
        .len_o      (len)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic quiet(input string req);
        check(done == 1'b0, req, "done idle", 32'(done), 32'd0);
        check(err == 1'b0, req, "err idle", 32'(err), 32'd0);
    endtask

    // Send seq[0..n-1]; optional stalls; check result one register stage later.
    task automatic send_insn(input int n, input bit stalls, input bit exp_err,
                             input logic [1:0] ek, input logic [2:0] er,
                             input bit es, input logic [31:0] ei,
                             input logic [3:0] el, input string req);
        for (int k = 0; k < n; k++) begin
            if (stalls && ($urandom % 3 == 0)) begin
                @(negedge clk);
                if (k > 0) quiet("R9");
                in_valid = 1'b0;
            end
            @(negedge clk);
            if (k > 0) quiet("R9");
            in_valid = 1'b1;
            in_byte  = seq[k];
        end
        @(negedge clk);
        in_valid = 1'b0;
        if (exp_err) begin
            check(err == 1'b1, req, "err pulse", 32'(err), 32'd1);
            check(done == 1'b0, req, "no done on error", 32'(done), 32'd0);
        end else begin
            check(done == 1'b1, req, "done pulse", 32'(done), 32'd1);
            check(err == 1'b0, req, "no err", 32'(err), 32'd0);
            check(kind == ek, req, "kind", 32'(kind), 32'(ek));
            check(regc == er, req, "reg", 32'(regc), 32'(er));
            check(size16 == es, req, "size flag", 32'(size16), 32'(es));
            check(imm == ei, req, "immediate", imm, ei);
            check(len == el, req, "length", 32'(len), 32'(el));
        end
        @(negedge clk);
        quiet("R9");
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int seed;
        logic [2:0]  r;
        logic [31:0] v;
        logic [7:0]  b;
        seed = 32'd7321;
        void'($urandom(seed));

        // R1 / R10: reset state
        repeat (2) @(negedge clk);
        check(in_ready == 1'b0, "R10", "ready in reset", 32'(in_ready), 32'd0);
        check(done == 1'b0 && err == 1'b0, "R1", "pulses in reset",
              {30'd0, done, err}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check(in_ready == 1'b1, "R10", "ready after reset", 32'(in_ready), 32'd1);
        quiet("R1");

        // Directed corner cases
        seq = '{8'hB8, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00};
        send_insn(5, 0, 0, 2'd1, 3'd0, 0, 32'h1, 4'd5, "R3");
        seq = '{8'hBB, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
        send_insn(5, 0, 0, 2'd1, 3'd3, 0, 32'h0, 4'd5, "R2");
        seq = '{8'hB8, 8'hAA, 8'hBB, 8'hCC, 8'hDD, 8'h00};
        send_insn(5, 0, 0, 2'd1, 3'd0, 0, 32'hDDCCBBAA, 4'd5, "R3");
        seq = '{8'h66, 8'hB8, 8'h01, 8'h00, 8'h00, 8'h00};
        send_insn(4, 0, 0, 2'd1, 3'd0, 1, 32'h1, 4'd4, "R4");
        seq = '{8'hCD, 8'h80, 8'h00, 8'h00, 8'h00, 8'h00};
        send_insn(2, 0, 0, 2'd2, 3'd0, 0, 32'h80, 4'd2, "R5");
        seq = '{8'h66, 8'hCD, 8'h80, 8'h00, 8'h00, 8'h00};
        send_insn(3, 0, 0, 2'd2, 3'd0, 1, 32'h80, 4'd3, "R6");
        seq = '{8'hBF, 8'h78, 8'h56, 8'h34, 8'h12, 8'h00};
        send_insn(5, 1, 0, 2'd1, 3'd7, 0, 32'h12345678, 4'd5, "R9");

        // R7: bad opcode after prefix, then prefix must be gone
        seq = '{8'h66, 8'h90, 8'h00, 8'h00, 8'h00, 8'h00};
        send_insn(2, 0, 1, 2'd0, 3'd0, 0, 32'h0, 4'd0, "R7");
        seq = '{8'hB9, 8'h11, 8'h22, 8'h33, 8'h44, 8'h00};
        send_insn(5, 0, 0, 2'd1, 3'd1, 0, 32'h44332211, 4'd5, "R7");

        // R8: doubled prefix
        seq = '{8'h66, 8'h66, 8'h00, 8'h00, 8'h00, 8'h00};
        send_insn(2, 0, 1, 2'd0, 3'd0, 0, 32'h0, 4'd0, "R8");
        seq = '{8'hBA, 8'h01, 8'h02, 8'h03, 8'h04, 8'h00};
        send_insn(5, 0, 0, 2'd1, 3'd2, 0, 32'h04030201, 4'd5, "R8");

        // R1: reset mid-instruction and with a pending prefix
        push(8'hB8);
        push(8'h11);
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        seq = '{8'hCD, 8'h21, 8'h00, 8'h00, 8'h00, 8'h00};
        send_insn(2, 0, 0, 2'd2, 3'd0, 0, 32'h21, 4'd2, "R1");
        push(8'h66);
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        seq = '{8'hBC, 8'hEF, 8'hBE, 8'hAD, 8'hDE, 8'h00};
        send_insn(5, 0, 0, 2'd1, 3'd4, 0, 32'hDEADBEEF, 4'd5, "R1");

        // Constrained random mix
        for (int i = 0; i < 300; i++) begin
            r = 3'($urandom);
            v = $urandom;
            case ($urandom % 5)
                0: begin
                    seq = '{8'hB8 + 8'(r), v[7:0], v[15:8], v[23:16], v[31:24], 8'h00};
                    send_insn(5, 1, 0, 2'd1, r, 0, v, 4'd5, "R3");
                end
                1: begin
                    seq = '{8'h66, 8'hB8 + 8'(r), v[7:0], v[15:8], 8'h00, 8'h00};
                    send_insn(4, 1, 0, 2'd1, r, 1, {16'd0, v[15:0]}, 4'd4, "R4");
                end
                2: begin
                    seq = '{8'hCD, v[7:0], 8'h00, 8'h00, 8'h00, 8'h00};
                    send_insn(2, 1, 0, 2'd2, 3'd0, 0, {24'd0, v[7:0]}, 4'd2, "R5");
                end
                3: begin
                    seq = '{8'h66, 8'hCD, v[7:0], 8'h00, 8'h00, 8'h00};
                    send_insn(3, 1, 0, 2'd2, 3'd0, 1, {24'd0, v[7:0]}, 4'd3, "R6");
                end
                default: begin
                    b = v[7:0];
                    while (b == 8'h66 || b == 8'hCD || b[7:3] == 5'b10111) b = b + 8'd1;
                    seq = '{b, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
                    send_insn(1, 0, 1, 2'd0, 3'd0, 0, 32'h0, 4'd0, "R7");
                end
            endcase
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule